// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is an 8-bit up-counter. A free-running binary divider sets its count rate, and a three-bit selector picks which tap of that divider the counter uses. Software chooses what an overflow does. In interval mode an overflow raises a status flag, and an interrupt request follows that flag. In watchdog mode an overflow produces a fixed-length pulse on an external output.

A small register bus reaches two byte-wide locations: the control/status register and the counter. Writes are 16 bits wide and carry a key in the upper byte. One key value updates the control/status register from the lower byte. A second key value loads the counter. Any other upper byte is discarded, so a stray store cannot reprogram the timer. The overflow flag has its own protection. Software must first read the flag as 1 and then write 0 to it. If another overflow arrives between that read and that write, the clear is cancelled.

Top module: `wdt_timer`

## Requirements
- R1: After reset the control/status register reads 0x18 (flag 0, interval mode, disabled, divide-by-2 select), the counter reads 0x00, and both `irq_o` and `wdt_ovf_o` are low.
- R2: A write with upper byte `CSR_KEY` (default 0xA5) loads the control/status register from the lower byte. A write with upper byte `CNT_KEY` (default 0x5A) loads the counter. A write with any other upper byte changes neither location.
- R3: While the enable bit (bit 5) is 0, the counter holds 0x00, and the prescaler is held cleared as well.
- R4: With the enable bit at 1, the counter steps once every 2^k system clocks. k is 1, 6, 7, 8, 9, 10, 12 or 13 for select codes 0 to 7 in bits 2..0. The first step comes 2^k clocks after the enabling write.
- R5: In interval mode (bit 6 = 0), the step past 0xFF wraps the counter to 0x00 and sets the overflow flag (bit 7). From a divide-by-2 enable, this happens on the 512th clock after the enabling write. `irq_o` equals the flag.
- R6: In watchdog mode (bit 6 = 1), an overflow drives `wdt_ovf_o` high for exactly `PULSE_LEN` clocks, starting at the overflow edge, and does not set the flag.
- R7: The flag clears only when a keyed control write with bit 7 = 0 follows a read of the control/status register that returned the flag as 1. A write of 0 without that read leaves the flag set. Writing 1 never sets the flag.
- R8: If an overflow sets the flag again after the arming read and before the write of 0, that write leaves the flag set.
- R9: Bits 4 and 3 of the control/status register always read as 1, whatever value was written to them.
- R10: A counter load takes priority over a simultaneous count step. The loaded value reads back on the next cycle, and counting continues from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 1 | Read select: 0 control/status, 1 counter |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 16 | Key (upper byte) and data (lower byte) |
| bus_rdata | output | 8 | Combinational read data |
| irq_o | output | 1 | Interval-mode interrupt request |
| wdt_ovf_o | output | 1 | Watchdog overflow pulse |

## Verification
The bench keeps the default keys and divider taps and shortens `PULSE_LEN` to 16. With that setting, both the rising and the falling edge of the watchdog pulse can be checked to the exact cycle. The divide-by-2 tap brings a full 256-step wrap within 512 clocks, so overflow, flag arming and the disarm race are checked with exact edge timing. The divide-by-64 tap and the slowest tap, divide-by-8192, are checked by sampling the counter one cycle before and one cycle after an expected step.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int PRE_W = 13;
    localparam int CNT_W = 8;

    typedef enum logic [2:0] {
        SEL_D2    = 3'd0,
        SEL_D64   = 3'd1,
        SEL_D128  = 3'd2,
        SEL_D256  = 3'd3,
        SEL_D512  = 3'd4,
        SEL_D1024 = 3'd5,
        SEL_D4096 = 3'd6,
        SEL_D8192 = 3'd7
    } rate_sel_e;

    typedef struct packed {
        logic      flag;
        logic      wd_mode;
        logic      run;
        rate_sel_e rate;
    } ctl_t;

    function automatic int tap_bits(input rate_sel_e s);
        case (s)
            SEL_D2:    return 1;
            SEL_D64:   return 6;
            SEL_D128:  return 7;
            SEL_D256:  return 8;
            SEL_D512:  return 9;
            SEL_D1024: return 10;
            SEL_D4096: return 12;
            default:   return 13;
        endcase
    endfunction

    function automatic logic [7:0] ctl_image(input ctl_t c);
        return {c.flag, c.wd_mode, c.run, 2'b11, c.rate};
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  rate_sel_e rate,
    output logic      tick
);
    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst || !run) div_q <= '0;
        else             div_q <= div_q + 1'b1;
    end

    always_comb begin
        mask = {PRE_W{1'b1}} >> (PRE_W - tap_bits(rate));
        tick = run && ((div_q & mask) == mask);
    end

    // R4: a tap enable is never wider than one cycle
    assert_tick_single_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt
);
    assign ovf_evt = run && tick && !load && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (tick)   cnt <= cnt + 1'b1;
    end

    assert_hold_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (run && load) |=> cnt == $past(load_val));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter logic [7:0] CSR_KEY   = 8'hA5,
    parameter logic [7:0] CNT_KEY   = 8'h5A,
    parameter int         PULSE_LEN = 128,
    localparam int        PW        = $clog2(PULSE_LEN + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rd,
    input  logic        bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    input  logic        ovf_evt,
    output ctl_t        ctl_q,
    output logic        cnt_load,
    output logic        irq_o,
    output logic        wdt_ovf_o
);
    logic          csr_wr;
    logic          armed_q;
    logic          set_evt;
    logic [PW-1:0] pulse_q;

    assign csr_wr   = bus_wr && (bus_wdata[15:8] == CSR_KEY);
    assign cnt_load = bus_wr && (bus_wdata[15:8] == CNT_KEY);
    assign set_evt  = ovf_evt && !ctl_q.wd_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q   <= '{flag: 1'b0, wd_mode: 1'b0, run: 1'b0, rate: SEL_D2};
            armed_q <= 1'b0;
        end else begin
            if (csr_wr) begin
                ctl_q.wd_mode <= bus_wdata[6];
                ctl_q.run     <= bus_wdata[5];
                ctl_q.rate    <= rate_sel_e'(bus_wdata[2:0]);
            end
            if (set_evt)
                ctl_q.flag <= 1'b1;
            else if (csr_wr && armed_q && !bus_wdata[7])
                ctl_q.flag <= 1'b0;
            if (set_evt || csr_wr)
                armed_q <= 1'b0;
            else if (bus_rd && !bus_addr && ctl_q.flag)
                armed_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                         pulse_q <= '0;
        else if (ovf_evt && ctl_q.wd_mode) pulse_q <= PW'(PULSE_LEN);
        else if (pulse_q != '0)          pulse_q <= pulse_q - 1'b1;
    end

    assign wdt_ovf_o = (pulse_q != '0);
    assign irq_o     = ctl_q.flag;

    assert_flag_source_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ctl_q.flag) |-> $past(ovf_evt && !ctl_q.wd_mode));
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ctl_q.flag) |-> $past(bus_wr && bus_wdata[15:8] == CSR_KEY && !bus_wdata[7]));
    assert_pulse_start_R6: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && ctl_q.wd_mode) |=> wdt_ovf_o);
    assert_pulse_source_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_ovf_o) |-> $past(ovf_evt && ctl_q.wd_mode));
    assert_bad_key_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wdata[15:8] != CSR_KEY && !ovf_evt) |=> $stable(ctl_q));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
    import wdt_pkg::*;
#(
    parameter logic [7:0] CSR_KEY   = 8'hA5,
    parameter logic [7:0] CNT_KEY   = 8'h5A,
    parameter int         PULSE_LEN = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rd,
    input  logic        bus_addr,
    input  logic        bus_wr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_o,
    output logic        wdt_ovf_o
);
    ctl_t             ctl_q;
    logic             tick;
    logic             cnt_load;
    logic             ovf_evt;
    logic [CNT_W-1:0] cnt;

    wdt_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (ctl_q.run),
        .rate (ctl_q.rate),
        .tick (tick)
    );

    wdt_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (ctl_q.run),
        .tick     (tick),
        .load     (cnt_load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt),
        .ovf_evt  (ovf_evt)
    );

    wdt_ctrl #(
        .CSR_KEY   (CSR_KEY),
        .CNT_KEY   (CNT_KEY),
        .PULSE_LEN (PULSE_LEN)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .ovf_evt   (ovf_evt),
        .ctl_q     (ctl_q),
        .cnt_load  (cnt_load),
        .irq_o     (irq_o),
        .wdt_ovf_o (wdt_ovf_o)
    );

    assign bus_rdata = bus_addr ? cnt : ctl_image(ctl_q);

    assert_fixed_bits_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_addr |-> bus_rdata[4:3] == 2'b11);
endmodule

// File: tb/wdt_timer_tb_top.sv
module wdt_timer_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  PULSE      = 16;
    localparam int  WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        irq_o;
    logic        wdt_ovf_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    wdt_timer #(.PULSE_LEN(PULSE)) dut_i (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wdt_ovf_o(wdt_ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] key, input logic [7:0] data);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = {key, data};
        @(negedge clk); bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        do_read(1'b0, d); check("R1 csr", d, 8'h18);
        do_read(1'b1, d); check("R1 cnt", d, 8'h00);
        check("R1 irq", irq_o, 1'b0);
        check("R1 wdt", wdt_ovf_o, 1'b0);
    endtask

    task automatic t_keys();
        logic [7:0] d;
        do_reset();
        do_write(8'h12, 8'h67);
        do_read(1'b0, d); check("R2 bad key csr", d, 8'h18);
        do_write(8'hA5, 8'h47);
        do_read(1'b0, d); check("R2 good key csr + R9", d, 8'h5F);
        do_write(8'hA5, 8'h98);
        do_read(1'b0, d); check("R9 fixed bits, R7 write 1 no set", d, 8'h18);
        do_write(8'hA5, 8'h27);
        do_write(8'h5A, 8'h33);
        do_read(1'b1, d); check("R2 cnt key", d, 8'h33);
        do_write(8'h5B, 8'h99);
        do_read(1'b1, d); check("R2 bad key cnt", d, 8'h33);
    endtask

    task automatic t_hold();
        logic [7:0] d;
        do_reset();
        repeat (600) @(negedge clk);
        do_read(1'b1, d); check("R3 disabled holds", d, 8'h00);
        do_write(8'hA5, 8'h20);
        repeat (50) @(negedge clk);
        do_write(8'hA5, 8'h00);
        @(negedge clk);
        do_read(1'b1, d); check("R3 cleared on disable", d, 8'h00);
        repeat (100) @(negedge clk);
        check("R3 no irq", irq_o, 1'b0);
    endtask

    task automatic t_rate(input logic [2:0] code, input int div);
        logic [7:0] d;
        do_reset();
        do_write(8'hA5, {5'b00100, code});
        repeat (div - 2) @(negedge clk);
        do_read(1'b1, d); check($sformatf("R4 before step sel%0d", code), d, 8'h00);
        do_read(1'b1, d); check($sformatf("R4 after step sel%0d", code), d, 8'h01);
    endtask

    task automatic t_interval();
        logic [7:0] d;
        do_reset();
        do_write(8'hA5, 8'h20);
        repeat (511) @(negedge clk);
        check("R5 irq before wrap", irq_o, 1'b0);
        @(negedge clk);
        check("R5 irq at wrap", irq_o, 1'b1);
        do_read(1'b1, d); check("R5 counter wrapped", d, 8'h00);
        do_write(8'hA5, 8'h20);
        check("R7 clear without read", irq_o, 1'b1);
        do_read(1'b0, d); check("R7 flag reads 1", d, 8'hB8);
        do_write(8'hA5, 8'h20);
        check("R7 clear after read", irq_o, 1'b0);
    endtask

    task automatic t_disarm();
        logic [7:0] d;
        do_reset();
        do_write(8'hA5, 8'h20);
        repeat (512) @(negedge clk);
        do_read(1'b0, d); check("R8 armed read", d[7], 1'b1);
        repeat (600) @(negedge clk);
        do_write(8'hA5, 8'h20);
        check("R8 clear lost to new overflow", irq_o, 1'b1);
        do_read(1'b0, d);
        do_write(8'hA5, 8'h20);
        check("R8 clear after rearm", irq_o, 1'b0);
    endtask

    task automatic t_watchdog();
        do_reset();
        do_write(8'hA5, 8'h60);
        repeat (511) @(negedge clk);
        check("R6 low before", wdt_ovf_o, 1'b0);
        @(negedge clk);
        check("R6 rise", wdt_ovf_o, 1'b1);
        repeat (PULSE - 1) @(negedge clk);
        check("R6 last high", wdt_ovf_o, 1'b1);
        @(negedge clk);
        check("R6 fall", wdt_ovf_o, 1'b0);
        check("R6 no flag", irq_o, 1'b0);
    endtask

    task automatic t_load();
        logic [7:0] d;
        do_reset();
        do_write(8'hA5, 8'h20);
        do_write(8'h5A, 8'hFD);
        do_read(1'b1, d); check("R10 loaded", d, 8'hFD);
        repeat (2) @(negedge clk);
        check("R10 counts on no wrap yet", irq_o, 1'b0);
        repeat (4) @(negedge clk);
        check("R10 wrap from loaded value", irq_o, 1'b1);
    endtask

    initial begin
        t_reset();
        t_keys();
        t_hold();
        t_rate(3'd0, 2);
        t_rate(3'd1, 64);
        t_rate(3'd7, 8192);
        t_interval();
        t_disarm();
        t_watchdog();
        t_load();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule